// File: doc/BRIEF.md
# Packet-Framed Asynchronous Transmit Queue Loader

This block is the host-facing write side of a transmit queue for asynchronous packets. Each queue entry is 33 bits wide: a 32-bit data word and a start-of-packet flag. The host frames a packet by choosing the address it writes to. One address opens a packet. A second address appends words without releasing them. A third appends words and releases the packet for sending. A fourth address takes a whole packet in one chip-select-held burst. Words become visible to the consumer only once their packet is released. A plain pop port stands in for the transmit serializer.

Framing mistakes put the block into a locked error state, and so does a pop from a queue that holds no released data. The locked state raises a bad-transmit interrupt and freezes all asynchronous traffic until software pulses the clear-queue control input. An arbitration request is held high while at least one released packet waits and the block is not locked. Host writes that arrive at a full queue are dropped and set a sticky overflow flag.

Top module: `atx_fifo_loader`

## Requirements
- R1: A write to address 80h stores the word with the start flag set to 1 and opens a packet. The word is not released, so `fifo_empty` stays 1 and `arb_req` stays 0.
- R2: A write to address 84h, single or burst, appends the word with the start flag set to 0 to the open packet and does not release it.
- R3: A write to address 8Ch appends the word with the start flag set to 0, closes the open packet and releases every word written so far. Further 8Ch words in the same unbroken chip-select run also become released, and the packet count rises by one per packet.
- R4: An unbroken chip-select-low run at address A0h stores one whole packet: the first word with the start flag set to 1 and the others with 0. The packet is released on the first clock edge at which the run has ended.
- R5: One word is taken on every rising clock edge at which `host_cs_n` is 0, and `host_ack_n` equals the value `host_cs_n` had one cycle earlier.
- R6: Each of these is a framing error that sets `bad_tx_irq` and stores nothing: a write to 84h or 8Ch with no open packet, a write to 80h while a packet is open, or the start of an A0h run while a packet is open.
- R7: A pop while no released word is present sets `bad_tx_irq`, and `pop_valid` stays 0.
- R8: While `bad_tx_irq` is 1, host writes and pops have no effect, and only `fifo_clr` returns the block to normal.
- R9: A one-cycle `fifo_clr` pulse empties the queue in one cycle and clears the packet count, the error state and the overflow flag.
- R10: `fifo_empty` is 1 exactly when no released word is queued. `arb_req` is 1 while `pkt_count` is nonzero and `bad_tx_irq` is 0.
- R11: A write that arrives while the queue holds DEPTH entries is dropped and sets the sticky `overflow` flag. This does not set `bad_tx_irq`.
- R12: A pop of a released word gives `pop_valid`, `pop_data` and `pop_first` one cycle later. Words come out in the order they were written. `pkt_count` drops by one on the cycle after a word with the start flag is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_n | input | 1 | Active-low chip select; one word per low cycle |
| host_addr | input | ADDR_W | Word address selecting the framing operation |
| host_wdata | input | DATA_W | Host write data |
| host_ack_n | output | 1 | Active-low acknowledge, one cycle behind chip select |
| fifo_clr | input | 1 | Clear-queue control pulse |
| pop | input | 1 | Consumer request for the next released word |
| pop_valid | output | 1 | Popped word valid this cycle |
| pop_data | output | DATA_W | Popped data word |
| pop_first | output | 1 | Popped word starts a packet |
| fifo_empty | output | 1 | No released word queued |
| arb_req | output | 1 | Request for bus arbitration |
| bad_tx_irq | output | 1 | Locked bad-transmit interrupt |
| overflow | output | 1 | Sticky flag for a write dropped at full |
| pkt_count | output | $clog2(DEPTH)+1 | Released packets whose first word is not yet delivered |

## Verification
Every packet length from the shortest legal one up to the full depth is loaded twice: once through the open/append/release addresses and once as a single A0h burst. Each packet is then drained and compared word by word with values computed in the bench. The two methods must give the same flags and ordering, which shows that the burst-start detection and the end-of-run release agree with the explicit framing. A separate run of release-address words shows that released data keeps growing within one chip-select run while the packet count rises only once. Each of the four framing errors, a pop from an empty queue, and writes made while locked are tried one at a time, so that a locked state, a dropped write and a clear can each be told apart from a silent store.

// File: rtl/atx_pkg.sv
package atx_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_FIRST  = 3'd1,
    OP_CONT   = 3'd2,
    OP_COMMIT = 3'd3,
    OP_BURST  = 3'd4
  } host_op_e;

  localparam logic [7:0] ADR_FIRST  = 8'h80;
  localparam logic [7:0] ADR_CONT   = 8'h84;
  localparam logic [7:0] ADR_COMMIT = 8'h8C;
  localparam logic [7:0] ADR_BURST  = 8'hA0;

endpackage

// File: rtl/atx_host_decode.sv
module atx_host_decode
  import atx_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] addr,
  output host_op_e          op,
  output host_op_e          prev_op,
  output logic              ack_n
);

  host_op_e dec_op;

  // Address decode; unknown addresses take no action.
  always_comb begin
    case (addr[7:0])
      ADR_FIRST:  dec_op = OP_FIRST;
      ADR_CONT:   dec_op = OP_CONT;
      ADR_COMMIT: dec_op = OP_COMMIT;
      ADR_BURST:  dec_op = OP_BURST;
      default:    dec_op = OP_NONE;
    endcase
    if (ADDR_W > 8 && (addr >> 8) != '0) dec_op = OP_NONE;
  end

  assign op = cs_n ? OP_NONE : dec_op;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_op <= OP_NONE;
      ack_n   <= 1'b1;
    end else begin
      prev_op <= op;
      ack_n   <= cs_n;
    end
  end

  AST_ACK_TRAILS_CS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ack_n == $past(cs_n))); // R5

endmodule

// File: rtl/atx_entry_ram.sv
module atx_entry_ram #(
  parameter int DEPTH = 8,
  parameter int EW    = 33,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [EW-1:0] rdata
);

  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/atx_frame_ctrl.sv
module atx_frame_ctrl
  import atx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  host_op_e      op,
  input  host_op_e      prev_op,
  input  logic          pop,
  input  logic          rd_first,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          wflag,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic          pop_valid,
  output logic          fifo_empty,
  output logic          arb_req,
  output logic          bad,
  output logic          ovf,
  output logic [PW-1:0] pkt_cnt
);

  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [PW-1:0] wptr, rptr, cptr;
  logic          pkt_open;

  logic [PW-1:0] used;
  logic          full, avail;
  logic          burst_end, open_eff;
  logic          w_store, w_flag, w_err, w_open, w_close, w_commit;
  logic          acc, drop, end_commit, cnt_inc, cnt_dec, underflow;

  assign used  = wptr - rptr;
  assign full  = (used == DEPTH_P);
  assign avail = (cptr != rptr);

  // An A0h run ends on the first cycle that is not another A0h word.
  assign burst_end = (prev_op == OP_BURST) && (op != OP_BURST);
  assign open_eff  = pkt_open && !burst_end;

  always_comb begin
    w_store  = 1'b0;
    w_flag   = 1'b0;
    w_err    = 1'b0;
    w_open   = 1'b0;
    w_close  = 1'b0;
    w_commit = 1'b0;
    case (op)
      OP_FIRST: begin
        if (open_eff) w_err = 1'b1;
        else begin
          w_store = 1'b1;
          w_flag  = 1'b1;
          w_open  = 1'b1;
        end
      end
      OP_CONT: begin
        if (!open_eff) w_err = 1'b1;
        else w_store = 1'b1;
      end
      OP_COMMIT: begin
        if (open_eff) begin
          w_store  = 1'b1;
          w_close  = 1'b1;
          w_commit = 1'b1;
        end else if (prev_op == OP_COMMIT) begin
          w_store  = 1'b1;
          w_commit = 1'b1;
        end else begin
          w_err = 1'b1;
        end
      end
      OP_BURST: begin
        if (prev_op != OP_BURST) begin
          if (open_eff) w_err = 1'b1;
          else begin
            w_store = 1'b1;
            w_flag  = 1'b1;
            w_open  = 1'b1;
          end
        end else begin
          w_store = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign acc        = w_store && !full && !bad;
  assign drop       = w_store && full && !bad;
  assign end_commit = burst_end && pkt_open && !bad;
  assign cnt_inc    = end_commit || (acc && w_close);
  assign cnt_dec    = pop_valid && rd_first;
  assign underflow  = pop && !avail && !bad;

  assign we    = acc;
  assign waddr = wptr[AW-1:0];
  assign wflag = w_flag;
  assign re    = pop && avail && !bad;
  assign raddr = rptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr      <= '0;
      rptr      <= '0;
      cptr      <= '0;
      pkt_open  <= 1'b0;
      bad       <= 1'b0;
      ovf       <= 1'b0;
      pkt_cnt   <= '0;
      pop_valid <= 1'b0;
    end else begin
      pop_valid <= re;
      pkt_cnt   <= pkt_cnt + PW'(cnt_inc) - PW'(cnt_dec);
      if (end_commit) begin
        cptr     <= wptr;
        pkt_open <= 1'b0;
      end
      if (acc) begin
        wptr <= wptr + 1'b1;
        if (w_open)   pkt_open <= 1'b1;
        if (w_close)  pkt_open <= 1'b0;
        if (w_commit) cptr <= wptr + 1'b1;
      end
      if (drop) ovf <= 1'b1;
      if (re) rptr <= rptr + 1'b1;
      if ((w_err && !bad) || underflow) bad <= 1'b1;
    end
  end

  assign fifo_empty = !avail;
  assign arb_req    = (pkt_cnt != '0) && !bad;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (wptr - rptr) <= DEPTH_P); // R11

  AST_RELEASED_WITHIN_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    (cptr - rptr) <= (wptr - rptr)); // R3

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (bad && !clr) |=> bad); // R8

  AST_LOCK_FREEZES_WRITES: assert property (@(posedge clk) disable iff (rst)
    (bad && !clr) |=> $stable(wptr)); // R8

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!avail && !bad && !ovf && pkt_cnt == '0)); // R9

endmodule

// File: rtl/atx_fifo_loader.sv
module atx_fifo_loader
  import atx_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1,
  localparam int EW    = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_cs_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ack_n,
  input  logic              fifo_clr,
  input  logic              pop,
  output logic              pop_valid,
  output logic [DATA_W-1:0] pop_data,
  output logic              pop_first,
  output logic              fifo_empty,
  output logic              arb_req,
  output logic              bad_tx_irq,
  output logic              overflow,
  output logic [PW-1:0]     pkt_count
);

  host_op_e      op, prev_op;
  logic          we, re, wflag;
  logic [AW-1:0] waddr, raddr;
  logic [EW-1:0] rdata;

  atx_host_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (host_cs_n),
    .addr    (host_addr),
    .op      (op),
    .prev_op (prev_op),
    .ack_n   (host_ack_n)
  );

  atx_frame_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .clr        (fifo_clr),
    .op         (op),
    .prev_op    (prev_op),
    .pop        (pop),
    .rd_first   (rdata[DATA_W]),
    .we         (we),
    .waddr      (waddr),
    .wflag      (wflag),
    .re         (re),
    .raddr      (raddr),
    .pop_valid  (pop_valid),
    .fifo_empty (fifo_empty),
    .arb_req    (arb_req),
    .bad        (bad_tx_irq),
    .ovf        (overflow),
    .pkt_cnt    (pkt_count)
  );

  atx_entry_ram #(.DEPTH(DEPTH), .EW(EW)) u_ram (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata ({wflag, host_wdata}),
    .re    (re),
    .raddr (raddr),
    .rdata (rdata)
  );

  assign pop_data  = rdata[DATA_W-1:0];
  assign pop_first = rdata[DATA_W];

  AST_POP_ONLY_RELEASED: assert property (@(posedge clk) disable iff (rst)
    pop_valid |-> $past(!fifo_empty)); // R7

  AST_ARB_NEEDS_PACKET: assert property (@(posedge clk) disable iff (rst)
    (arb_req && !fifo_clr && !pop_valid) |=> (pkt_count != '0) || bad_tx_irq); // R10

endmodule

// File: tb/tb_atx_fifo_loader.sv
module tb_atx_fifo_loader;

  localparam int DEPTH = 8;
  localparam int PW    = $clog2(DEPTH) + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_cs_n = 1'b1;
  logic [7:0]    host_addr = '0;
  logic [31:0]   host_wdata = '0;
  logic          host_ack_n;
  logic          fifo_clr = 1'b0;
  logic          pop = 1'b0;
  logic          pop_valid;
  logic [31:0]   pop_data;
  logic          pop_first;
  logic          fifo_empty, arb_req, bad_tx_irq, overflow;
  logic [PW-1:0] pkt_count;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  atx_fifo_loader #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .host_cs_n(host_cs_n), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_ack_n(host_ack_n), .fifo_clr(fifo_clr),
    .pop(pop), .pop_valid(pop_valid), .pop_data(pop_data), .pop_first(pop_first),
    .fifo_empty(fifo_empty), .arb_req(arb_req), .bad_tx_irq(bad_tx_irq),
    .overflow(overflow), .pkt_count(pkt_count)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr1(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_cs_n = 1'b0; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_cs_n = 1'b1;
  endtask

  task automatic burst(input logic [7:0] a, input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) check("R5", "ack_n during burst", host_ack_n, 0);
      host_cs_n = 1'b0; host_addr = a; host_wdata = base + i;
    end
    @(negedge clk);
    check("R5", "ack_n on last word", host_ack_n, 0);
    host_cs_n = 1'b1;
    @(negedge clk);
    check("R5", "ack_n after run", host_ack_n, 1);
  endtask

  task automatic pop_chk(input string req, input bit ev, input logic [31:0] ed, input bit ef);
    @(negedge clk);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    check(req, "pop_valid", pop_valid, ev);
    if (ev) begin
      check(req, "pop_data", pop_data, ed);
      check(req, "pop_first", pop_first, ef);
    end
  endtask

  task automatic clear_q();
    @(negedge clk);
    fifo_clr = 1'b1;
    @(negedge clk);
    fifo_clr = 1'b0;
  endtask

  task automatic idle_chk(input string req);
    check(req, "fifo_empty", fifo_empty, 1);
    check(req, "arb_req", arb_req, 0);
    check(req, "pkt_count", pkt_count, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state
    idle_chk("R10");
    check("R8", "bad after reset", bad_tx_irq, 0);
    check("R11", "overflow after reset", overflow, 0);
    check("R5", "ack idle", host_ack_n, 1);

    // Sweep: explicit framing, lengths 2..DEPTH (R1 R2 R3 R12)
    for (int n = 2; n <= DEPTH; n++) begin
      logic [31:0] base;
      base = 32'h1000_0000 | (n << 8);
      wr1(8'h80, base);
      check("R1", "open packet not released", fifo_empty, 1);
      check("R1", "no arb before release", arb_req, 0);
      if (n > 2) burst(8'h84, n - 2, base + 1);
      check("R2", "appended words not released", fifo_empty, 1);
      wr1(8'h8C, base + n - 1);
      check("R3", "released", fifo_empty, 0);
      check("R3", "pkt_count", pkt_count, 1);
      check("R10", "arb_req", arb_req, 1);
      for (int i = 0; i < n; i++) pop_chk("R12", 1, base + i, i == 0);
      @(negedge clk);
      idle_chk("R12");
    end

    // Sweep: whole-packet bursts, lengths 1..DEPTH (R4)
    for (int n = 1; n <= DEPTH; n++) begin
      logic [31:0] base;
      base = 32'h2000_0000 | (n << 8);
      burst(8'hA0, n, base);
      check("R4", "burst released", fifo_empty, 0);
      check("R4", "pkt_count", pkt_count, 1);
      for (int i = 0; i < n; i++) pop_chk("R4", 1, base + i, i == 0);
      @(negedge clk);
      idle_chk("R4");
    end

    // Two queued packets, and a run of release-address words
    wr1(8'h80, 32'h3000_0000);
    burst(8'h8C, 3, 32'h3000_0001);
    check("R3", "release run counts once", pkt_count, 1);
    burst(8'hA0, 2, 32'h3000_0010);
    check("R3", "two packets", pkt_count, 2);
    for (int i = 0; i < 4; i++) pop_chk("R3", 1, 32'h3000_0000 + i, i == 0);
    @(negedge clk);
    check("R12", "count after first packet", pkt_count, 1);
    pop_chk("R12", 1, 32'h3000_0010, 1);
    pop_chk("R12", 1, 32'h3000_0011, 0);
    @(negedge clk);
    idle_chk("R12");

    // Framing errors (R6) and lock behaviour (R8)
    wr1(8'h84, 32'hDEAD_0001);
    check("R6", "cont without open", bad_tx_irq, 1);
    wr1(8'h80, 32'hDEAD_0002);
    wr1(8'h8C, 32'hDEAD_0003);
    idle_chk("R8");
    pop_chk("R8", 0, 0, 0);
    check("R8", "still locked", bad_tx_irq, 1);
    clear_q();
    check("R9", "clear unlocks", bad_tx_irq, 0);
    pop_chk("R8", 0, 0, 0);
    clear_q();

    wr1(8'h8C, 32'hDEAD_0004);
    check("R6", "release without open", bad_tx_irq, 1);
    clear_q();
    wr1(8'h80, 32'hDEAD_0005);
    wr1(8'h80, 32'hDEAD_0006);
    check("R6", "second open", bad_tx_irq, 1);
    clear_q();
    wr1(8'h80, 32'hDEAD_0007);
    wr1(8'hA0, 32'hDEAD_0008);
    check("R6", "burst start while open", bad_tx_irq, 1);
    clear_q();
    idle_chk("R9");

    // Underflow (R7)
    pop_chk("R7", 0, 0, 0);
    check("R7", "underflow locks", bad_tx_irq, 1);
    clear_q();

    // Clear with a released packet queued (R9)
    burst(8'hA0, 3, 32'h4000_0000);
    check("R9", "loaded before clear", pkt_count, 1);
    clear_q();
    idle_chk("R9");
    check("R9", "no error after clear", bad_tx_irq, 0);

    // Overflow (R11)
    wr1(8'h80, 32'h5000_0000);
    burst(8'h84, DEPTH - 1, 32'h5000_0001);
    check("R11", "no overflow at exactly full", overflow, 0);
    wr1(8'h84, 32'h5000_00FF);
    check("R11", "overflow set", overflow, 1);
    check("R11", "no lock on overflow", bad_tx_irq, 0);
    wr1(8'h8C, 32'h5000_00FE);
    check("R11", "release dropped", fifo_empty, 1);
    check("R11", "overflow sticky", overflow, 1);
    clear_q();
    check("R9", "overflow cleared", overflow, 0);
    idle_chk("R9");

    // Normal operation after recovery
    wr1(8'h80, 32'h6000_0000);
    wr1(8'h8C, 32'h6000_0001);
    pop_chk("R12", 1, 32'h6000_0000, 1);
    pop_chk("R12", 1, 32'h6000_0001, 0);
    @(negedge clk);
    idle_chk("R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule